// File: doc/BRIEF.md
# Multi-Waveform Test Signal Generator

This block is a streaming source of complex test samples. Software programs it through a 32-bit write-only register window of 32 bytes. The window selects one of three waveforms: a programmable constant, the output of an external phasor rotator, or pseudo-random noise. The selected sample is scaled by a signed fractional gain and then rounded and saturated back to 16 bits per component. Each output word carries I in bits 31:16 and Q in bits 15:0, both signed 16-bit.

While the block is enabled, it sends one sample on every accepted valid/ready transfer. The stream is cut into packets of a programmable number of samples, and the last sample of each packet carries a flag. The rotator is a separate block. This block gives the rotator its phase step and its start phasor. It takes the rotator's current sample and pulses an advance strobe each time that sample is consumed. The noise source holds one linear feedback shift register for each component.

Top module: `tsg_top`

## Requirements
- R1: After a synchronous reset, the block is in this state: `out_valid` is 0, enable is off, the waveform is constant, gain is 32767, the constant, phase step and start phasor are 0, and packet length is `DEFAULT_SPP`.
- R2: Bit 0 of the word at offset 0x00 enables generation. While it is 0, no new sample becomes valid. A sample already presented with `out_ready` low stays presented until it is accepted. When generation is re-enabled, the packet position resumes where it stopped.
- R3: Waveform code 0 at offset 0x08 selects the constant at offset 0x10, with I in bits 31:16 and Q in bits 15:0. Code 3 also selects the constant.
- R4: Waveform code 1 outputs `rot_sample` (I in 31:16, Q in 15:0). `rot_advance` is high for exactly the cycles in which such a sample is loaded into the output register.
- R5: Waveform code 2 outputs noise. I starts from seed 0xACE1 and Q from seed 0x1D2B. Each register steps once per emitted noise sample, by the rule next = {s[14:0], parity(s & 0xD008)}. The sample shows the current state, before the step.
- R6: Each component equals round-half-up(s·g / 32768), saturated to [-32768, 32767]. Here g is the signed 16-bit gain at offset 0x0C.
- R7: Each packet has exactly N samples, where N is the value at offset 0x04. `out_last` is 1 on the Nth sample only.
- R8: A packet length of 0 gives packets of one sample each, with `out_last` set on every sample.
- R9: A new packet length takes effect from the first sample of the next packet. The packet in progress keeps its length.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_last` hold their values, and no waveform state advances (no LFSR step, no `rot_advance`).
- R11: `rot_phase_inc` shows bits 15:0 written at 0x14, and `rot_start` shows the word written at 0x18, one cycle after the write. A write to an unmapped offset (0x1C) changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 5 | Byte offset within the register window |
| reg_wr_data | input | 32 | Register write data |
| rot_sample | input | 32 | Current rotator sample, I high / Q low |
| rot_advance | output | 1 | Rotator sample consumed this cycle |
| rot_phase_inc | output | 16 | Phase step to the rotator |
| rot_start | output | 32 | Start phasor to the rotator |
| out_data | output | 32 | Output sample, I high / Q low |
| out_valid | output | 1 | Output sample valid |
| out_last | output | 1 | Last sample of a packet |
| out_ready | input | 1 | Downstream accepts the sample |

## Verification
A corrupted packet counter or latched length shows up at the first `out_last` that falls out of place, which is at most one packet later. A noise register that stepped too often or too rarely changes every later noise word. A spurious or missing rotator strobe skews the rotator index against the sample sequence the bench expects, and this shows in the very next compare. The bench's reference model is compared with the ports on every clock, while the ready pattern is irregular. A fault that breaks the hold under backpressure is therefore seen in the cycle after the stall.

// File: rtl/tsg_pkg.sv
package tsg_pkg;
  typedef enum logic [1:0] {
    WAVE_CONST = 2'd0,
    WAVE_SINE  = 2'd1,
    WAVE_NOISE = 2'd2,
    WAVE_ALT   = 2'd3
  } wave_t;

  localparam int WORD_ENABLE = 0;
  localparam int WORD_SPP    = 1;
  localparam int WORD_WAVE   = 2;
  localparam int WORD_GAIN   = 3;
  localparam int WORD_CONST  = 4;
  localparam int WORD_PHASE  = 5;
  localparam int WORD_START  = 6;
endpackage

// File: rtl/tsg_regs.sv
module tsg_regs
  import tsg_pkg::*;
#(
  parameter int ADDR_W       = 5,
  parameter int DATA_W       = 32,
  parameter int SAMPLE_W     = 16,
  parameter int SPP_W        = 16,
  parameter int DEFAULT_SPP  = 16,
  parameter int DEFAULT_GAIN = 32767
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  output logic                enable,
  output logic [SPP_W-1:0]    spp,
  output wave_t               wave,
  output logic [SAMPLE_W-1:0] gain,
  output logic [SAMPLE_W-1:0] const_i,
  output logic [SAMPLE_W-1:0] const_q,
  output logic [SAMPLE_W-1:0] phase_inc,
  output logic [DATA_W-1:0]   start_phasor
);
  localparam int IDX_LSB = 2;
  localparam int IDX_W   = ADDR_W - IDX_LSB;

  logic [IDX_W-1:0] idx;
  assign idx = wr_addr[ADDR_W-1:IDX_LSB];

  always_ff @(posedge clk) begin
    if (rst) begin
      enable       <= 1'b0;
      spp          <= SPP_W'(DEFAULT_SPP);
      wave         <= WAVE_CONST;
      gain         <= SAMPLE_W'(DEFAULT_GAIN);
      const_i      <= '0;
      const_q      <= '0;
      phase_inc    <= '0;
      start_phasor <= '0;
    end else if (wr_en) begin
      case (int'(idx))
        WORD_ENABLE: enable       <= wr_data[0];
        WORD_SPP:    spp          <= wr_data[SPP_W-1:0];
        WORD_WAVE:   wave         <= wave_t'(wr_data[1:0]);
        WORD_GAIN:   gain         <= wr_data[SAMPLE_W-1:0];
        WORD_CONST: begin
          const_i <= wr_data[2*SAMPLE_W-1:SAMPLE_W];
          const_q <= wr_data[SAMPLE_W-1:0];
        end
        WORD_PHASE:  phase_inc    <= wr_data[SAMPLE_W-1:0];
        WORD_START:  start_phasor <= wr_data;
        default: ;
      endcase
    end
  end

  // R11: an unmapped word leaves the start phasor untouched
  p_unmapped_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    (wr_en && int'(idx) > WORD_START) |=> $stable(start_phasor) && $stable(phase_inc));
endmodule

// File: rtl/tsg_noise.sv
module tsg_noise #(
  parameter int                W      = 16,
  parameter logic [W-1:0]      TAPS   = 16'hD008,
  parameter logic [W-1:0]      SEED_I = 16'hACE1,
  parameter logic [W-1:0]      SEED_Q = 16'h1D2B
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  output logic [W-1:0] noise_i,
  output logic [W-1:0] noise_q
);
  localparam int LANES = 2;

  logic [W-1:0] state [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam logic [W-1:0] SEED = (g == 0) ? SEED_I : SEED_Q;
    logic fb;
    assign fb = ^(state[g] & TAPS);

    always_ff @(posedge clk) begin
      if (rst)       state[g] <= SEED;
      else if (step) state[g] <= {state[g][W-2:0], fb};
    end

    // R5: a maximal-length register never falls into the all-zero lock
    p_lfsr_live_r5: assert property (@(posedge clk) disable iff (rst)
      state[g] != '0);
    // R10: state moves only on a step request
    p_lfsr_idle_r10: assert property (@(posedge clk) disable iff (rst)
      !step |=> $stable(state[g]));
  end

  assign noise_i = state[0];
  assign noise_q = state[1];
endmodule

// File: rtl/tsg_gain.sv
module tsg_gain #(
  parameter int SAMPLE_W = 16
) (
  input  logic [2*SAMPLE_W-1:0] din,
  input  logic [SAMPLE_W-1:0]   gain,
  output logic [2*SAMPLE_W-1:0] dout
);
  localparam int PW = 2*SAMPLE_W + 1;
  localparam logic signed [PW-1:0] RND  = PW'(1) <<< (SAMPLE_W-2);
  localparam logic signed [PW-1:0] MAXV = PW'((1 << (SAMPLE_W-1)) - 1);
  localparam logic signed [PW-1:0] MINV = -(PW'(1) <<< (SAMPLE_W-1));

  for (genvar c = 0; c < 2; c++) begin : g_comp
    logic signed [SAMPLE_W-1:0]   s;
    logic signed [2*SAMPLE_W-1:0] prod;
    logic signed [PW-1:0]         rnd;
    logic signed [PW-1:0]         sh;
    logic        [SAMPLE_W-1:0]   res;

    assign s    = din[c*SAMPLE_W +: SAMPLE_W];
    assign prod = s * $signed(gain);
    assign rnd  = {prod[2*SAMPLE_W-1], prod} + RND;
    assign sh   = rnd >>> (SAMPLE_W-1);

    always_comb begin
      if (sh > MAXV)      res = MAXV[SAMPLE_W-1:0];
      else if (sh < MINV) res = MINV[SAMPLE_W-1:0];
      else                res = sh[SAMPLE_W-1:0];
    end

    assign dout[c*SAMPLE_W +: SAMPLE_W] = res;
  end
endmodule

// File: rtl/tsg_framer.sv
module tsg_framer #(
  parameter int DATA_W = 32,
  parameter int SPP_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [SPP_W-1:0]  spp_cfg,
  input  logic [DATA_W-1:0] sample_in,
  output logic              advance,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  output logic              out_last,
  input  logic              out_ready
);
  logic             load;
  logic [SPP_W-1:0] cnt;
  logic [SPP_W-1:0] spp_active;
  logic [SPP_W-1:0] spp_new;
  logic [SPP_W-1:0] spp_eff;
  logic             at_end;

  assign load    = !out_valid || out_ready;
  assign advance = load && enable;
  assign spp_new = (spp_cfg == '0) ? SPP_W'(1) : spp_cfg;
  assign spp_eff = (cnt == '0) ? spp_new : spp_active;
  assign at_end  = (cnt == spp_eff - SPP_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_last   <= 1'b0;
      out_data   <= '0;
      cnt        <= '0;
      spp_active <= SPP_W'(1);
    end else if (load) begin
      if (enable) begin
        out_valid <= 1'b1;
        out_data  <= sample_in;
        out_last  <= at_end;
        cnt       <= at_end ? '0 : cnt + SPP_W'(1);
        if (cnt == '0) spp_active <= spp_new;
      end else begin
        out_valid <= 1'b0;
        out_last  <= 1'b0;
      end
    end
  end

  // R10: a stalled sample is held unchanged
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> out_valid && $stable(out_data) && $stable(out_last));
  // R2: nothing new becomes valid while disabled
  p_off_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (!enable && load) |=> !out_valid);
  // R7: position inside a packet stays below the latched length
  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0) |-> (cnt < spp_active));
  // R9: latched length changes only at a packet boundary
  p_spp_stable_r9: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0) |=> $stable(spp_active));
  // R8: the latched length is never zero
  p_spp_nonzero_r8: assert property (@(posedge clk) disable iff (rst)
    spp_active != '0);
endmodule

// File: rtl/tsg_top.sv
module tsg_top
  import tsg_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int SAMPLE_W    = 16,
  parameter int SPP_W       = 16,
  parameter int DEFAULT_SPP = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reg_wr_en,
  input  logic [ADDR_W-1:0]     reg_wr_addr,
  input  logic [31:0]           reg_wr_data,
  input  logic [2*SAMPLE_W-1:0] rot_sample,
  output logic                  rot_advance,
  output logic [SAMPLE_W-1:0]   rot_phase_inc,
  output logic [2*SAMPLE_W-1:0] rot_start,
  output logic [2*SAMPLE_W-1:0] out_data,
  output logic                  out_valid,
  output logic                  out_last,
  input  logic                  out_ready
);
  localparam int DW = 2*SAMPLE_W;

  logic                enable;
  logic [SPP_W-1:0]    spp;
  wave_t               wave;
  logic [SAMPLE_W-1:0] gain;
  logic [SAMPLE_W-1:0] const_i;
  logic [SAMPLE_W-1:0] const_q;
  logic [SAMPLE_W-1:0] noise_i;
  logic [SAMPLE_W-1:0] noise_q;
  logic [DW-1:0]       raw;
  logic [DW-1:0]       scaled;
  logic                advance;
  logic                noise_step;

  tsg_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DW), .SAMPLE_W(SAMPLE_W),
    .SPP_W(SPP_W), .DEFAULT_SPP(DEFAULT_SPP),
    .DEFAULT_GAIN((1 << (SAMPLE_W-1)) - 1)
  ) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(reg_wr_en), .wr_addr(reg_wr_addr), .wr_data(reg_wr_data),
    .enable(enable), .spp(spp), .wave(wave), .gain(gain),
    .const_i(const_i), .const_q(const_q),
    .phase_inc(rot_phase_inc), .start_phasor(rot_start)
  );

  assign noise_step  = advance && (wave == WAVE_NOISE);
  assign rot_advance = advance && (wave == WAVE_SINE);

  tsg_noise #(.W(SAMPLE_W)) u_noise (
    .clk(clk), .rst(rst), .step(noise_step),
    .noise_i(noise_i), .noise_q(noise_q)
  );

  always_comb begin
    case (wave)
      WAVE_SINE:  raw = rot_sample;
      WAVE_NOISE: raw = {noise_i, noise_q};
      default:    raw = {const_i, const_q};
    endcase
  end

  tsg_gain #(.SAMPLE_W(SAMPLE_W)) u_gain (
    .din(raw), .gain(gain), .dout(scaled)
  );

  tsg_framer #(.DATA_W(DW), .SPP_W(SPP_W)) u_framer (
    .clk(clk), .rst(rst), .enable(enable), .spp_cfg(spp),
    .sample_in(scaled), .advance(advance),
    .out_data(out_data), .out_valid(out_valid), .out_last(out_last),
    .out_ready(out_ready)
  );

  // R4: the rotator strobe is never issued while the output is stalled
  p_rot_stall_r4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !rot_advance);
endmodule

// File: tb/tsg_top_tb.sv
module tsg_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr_en = 1'b0;
  logic [4:0]  reg_wr_addr = '0;
  logic [31:0] reg_wr_data = '0;
  logic [31:0] rot_sample;
  logic        rot_advance;
  logic [15:0] rot_phase_inc;
  logic [31:0] rot_start;
  logic [31:0] out_data;
  logic        out_valid;
  logic        out_last;
  logic        out_ready = 1'b1;

  always #2.5 clk = ~clk;

  tsg_top u_dut (
    .clk(clk), .rst(rst),
    .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .rot_sample(rot_sample), .rot_advance(rot_advance),
    .rot_phase_inc(rot_phase_inc), .rot_start(rot_start),
    .out_data(out_data), .out_valid(out_valid), .out_last(out_last),
    .out_ready(out_ready)
  );

  int total = 0;
  int bad = 0;
  string cur_req = "R1";
  bit done = 0;

  function automatic logic [31:0] rot_val(input int k);
    logic [15:0] a, b;
    a = 16'(k * 4099 + 17);
    b = 16'(k * 7919) ^ 16'h8000;
    return {a, b};
  endfunction

  // external rotator stand-in: index moves on each strobe
  int rot_idx = 0;
  always @(posedge clk) begin
    if (rst) rot_idx <= 0;
    else if (rot_advance) rot_idx <= rot_idx + 1;
  end
  assign rot_sample = rot_val(rot_idx);

  function automatic logic [15:0] gmul(input logic [15:0] s, input logic [15:0] g);
    int p, r;
    p = int'($signed(s)) * int'($signed(g));
    r = (p + 16384) >>> 15;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return r[15:0];
  endfunction

  function automatic logic [15:0] lfsr_next(input logic [15:0] s);
    return {s[14:0], ^(s & 16'hD008)};
  endfunction

  // reference model
  bit          m_en, m_valid, m_last;
  int          m_spp, m_sppa, m_cnt, m_rot;
  logic [1:0]  m_wave;
  logic [15:0] m_gain, m_ci, m_cq, m_ph, m_li, m_lq;
  logic [31:0] m_start, m_data;

  always @(posedge clk) begin
    if (rst) begin
      m_en = 0; m_valid = 0; m_last = 0; m_spp = 16; m_sppa = 1; m_cnt = 0;
      m_rot = 0; m_wave = 0; m_gain = 16'd32767; m_ci = 0; m_cq = 0; m_ph = 0;
      m_start = 0; m_data = 0; m_li = 16'hACE1; m_lq = 16'h1D2B;
    end else begin
      if (!m_valid || out_ready) begin
        if (m_en) begin
          logic [31:0] s;
          int eff;
          case (m_wave)
            2'd1: begin s = rot_val(m_rot); m_rot++; end
            2'd2: begin s = {m_li, m_lq}; m_li = lfsr_next(m_li); m_lq = lfsr_next(m_lq); end
            default: s = {m_ci, m_cq};
          endcase
          m_data = {gmul(s[31:16], m_gain), gmul(s[15:0], m_gain)};
          if (m_cnt == 0) m_sppa = (m_spp == 0) ? 1 : m_spp;
          eff = m_sppa;
          m_valid = 1;
          m_last = (m_cnt == eff - 1);
          m_cnt = m_last ? 0 : m_cnt + 1;
        end else begin
          m_valid = 0; m_last = 0;
        end
      end
      if (reg_wr_en) begin
        case (reg_wr_addr[4:2])
          3'd0: m_en = reg_wr_data[0];
          3'd1: m_spp = int'(reg_wr_data[15:0]);
          3'd2: m_wave = reg_wr_data[1:0];
          3'd3: m_gain = reg_wr_data[15:0];
          3'd4: begin m_ci = reg_wr_data[31:16]; m_cq = reg_wr_data[15:0]; end
          3'd5: m_ph = reg_wr_data[15:0];
          3'd6: m_start = reg_wr_data;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(out_valid == m_valid, cur_req, "valid", 32'(out_valid), 32'(m_valid));
      if (m_valid) begin
        chk(out_data == m_data, cur_req, "data", out_data, m_data);
        chk(out_last == m_last, cur_req, "last", 32'(out_last), 32'(m_last));
      end
      chk(rot_idx == m_rot, "R4", "rotator advances", 32'(rot_idx), 32'(m_rot));
      chk(rot_phase_inc == m_ph, "R11", "phase step", 32'(rot_phase_inc), 32'(m_ph));
      chk(rot_start == m_start, "R11", "start phasor", rot_start, m_start);
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  // mode 0: always ready, 1: irregular, 2: never ready
  task automatic run(input int n, input int mode);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      case (mode)
        0: out_ready = 1'b1;
        1: out_ready = (($urandom % 4) != 0);
        default: out_ready = 1'b0;
      endcase
    end
    @(negedge clk);
    out_ready = 1'b1;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    cur_req = "R1";
    chk(out_valid == 1'b0, "R1", "reset valid", 32'(out_valid), 32'd0);
    chk(rot_start == 32'd0, "R1", "reset start", rot_start, 32'd0);
    chk(rot_phase_inc == 16'd0, "R1", "reset phase", 32'(rot_phase_inc), 32'd0);
    run(5, 0);

    cur_req = "R3";
    wr(5'h10, 32'h4000_E000);
    wr(5'h04, 32'd4);
    wr(5'h00, 32'd1);
    run(30, 0);

    cur_req = "R6";
    wr(5'h0C, 32'd16384);
    wr(5'h10, 32'h8000_0001);
    run(12, 0);
    wr(5'h0C, 32'h0000_8000);
    run(12, 0);
    wr(5'h10, 32'h7FFF_0003);
    wr(5'h0C, 32'd12345);
    run(12, 1);

    cur_req = "R10";
    run(10, 2);
    run(40, 1);

    cur_req = "R4";
    wr(5'h0C, 32'd32767);
    wr(5'h08, 32'd1);
    run(40, 0);
    run(60, 1);
    run(6, 2);

    cur_req = "R5";
    wr(5'h08, 32'd2);
    run(40, 0);
    run(60, 1);
    wr(5'h0C, 32'd9000);
    run(20, 1);

    cur_req = "R8";
    wr(5'h04, 32'd0);
    run(20, 1);

    cur_req = "R9";
    wr(5'h04, 32'd7);
    run(3, 0);
    wr(5'h04, 32'd3);
    run(30, 1);
    wr(5'h04, 32'd5);
    run(2, 0);
    wr(5'h04, 32'd2);
    run(25, 0);

    cur_req = "R7";
    wr(5'h04, 32'd6);
    run(50, 1);

    cur_req = "R3";
    wr(5'h08, 32'd3);
    wr(5'h10, 32'h1234_FEDC);
    run(20, 0);

    cur_req = "R2";
    wr(5'h00, 32'd0);
    run(15, 0);
    out_ready = 1'b0;
    wr(5'h00, 32'd1);
    wr(5'h00, 32'd0);
    run(6, 2);
    run(6, 0);
    wr(5'h00, 32'd1);
    run(20, 1);

    cur_req = "R11";
    wr(5'h14, 32'h0000_0C40);
    wr(5'h18, 32'h3A5C_0000);
    wr(5'h1C, 32'hFFFF_FFFF);
    run(10, 0);
    chk(rot_start == 32'h3A5C_0000, "R11", "start after unmapped write", rot_start, 32'h3A5C_0000);
    chk(rot_phase_inc == 16'h0C40, "R11", "phase after unmapped write", 32'(rot_phase_inc), 32'h0C40);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule